// File: doc/BRIEF.md
# Paged memory window translator

This block maps addresses in a host's lower 1 MB onto a 24-bit physical memory space, in 4 KB pages. A table of 256 entries, held in on-chip registers, gives each page a 12-bit frame number, an enable flag and a read-only flag. A host lookup presents a 20-bit address and a write flag. One clock later the block returns the translated address and four indications: hit, pass-through, write-protect and a write strobe that may go on toward memory.

The host fills the table through a byte-wide register port. It writes a page index, then a low data byte into a holding register, then a high data byte. The high-byte write commits the whole 16-bit entry at the current index. Reads of the data bytes return the stored entry at the current index. That copy is refreshed whenever the index is written and whenever an entry is committed.

Entry layout (the lookup decodes it): bit 15 enable, bit 14 read-only, bits 13:12 reserved (always stored as zero), bits 11:0 frame number. Register select encoding on `rg_sel`: 0 index, 1 low data byte, 2 high data byte, 3 unused.

Top module: `pgwin_xlat`

## Requirements
- R1: After reset every output is zero, the index register reads 0 and every table entry reads 0x0000, so every page is disabled.
- R2: A lookup that hits an entry with bit 15 set returns `xl_hit`=1, `xl_pass`=0 and `xl_addr` = {frame bits 11:0, host address bits 11:0}, where the entry is selected by host address bits 19:12.
- R3: A lookup of an entry with bit 15 clear returns `xl_pass`=1, `xl_hit`=0 and `xl_addr` equal to the host address zero-extended to 24 bits.
- R4: Results appear exactly one clock after the lookup is presented: `xl_valid` is `lk_valid` delayed by one cycle. While `xl_valid` is low, all other result outputs are zero.
- R5: A write to select 1 (low byte) changes no table entry. Lookups and data-byte reads still show the previously stored entry.
- R6: A write to select 2 (high byte) stores {wdata bits 7:6, 2'b00, wdata bits 3:0, held low byte} at the current index. Bits 13:12 of every entry read as zero.
- R7: With select 0, `rg_rdata` returns the index. Select 1 and select 2 return bits 7:0 and bits 15:8 of the stored entry at the index, reloaded when the index is written. Select 3 reads 0 and writes to it change nothing.
- R8: A write lookup of an enabled page with bit 14 set gives `xl_wprot`=1 and `xl_mem_we`=0. A read lookup gives `xl_wprot`=0 and `xl_mem_we`=0.
- R9: A write lookup of an enabled read-write page, or of a disabled page, gives `xl_mem_we`=1 and `xl_wprot`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_wr | input | 1 | Lookup is a write access |
| lk_addr | input | 20 | Host address to translate |
| xl_valid | output | 1 | Result valid |
| xl_addr | output | 24 | Translated or zero-extended address |
| xl_hit | output | 1 | Entry enabled, address translated |
| xl_pass | output | 1 | Entry disabled, address passed through |
| xl_wprot | output | 1 | Write blocked by read-only page |
| xl_mem_we | output | 1 | Write strobe allowed toward memory |
| rg_we | input | 1 | Register write strobe |
| rg_sel | input | 2 | Register select |
| rg_wdata | input | 8 | Register write data |
| rg_rdata | output | 8 | Register read data |

## Verification
Every lookup result is due on the first rising edge after the cycle in which `lk_valid` is presented. The scoreboard stamps each expected item with that cycle number, and the monitor checks 2 ns after each rising edge that the result arrives in exactly its stamped cycle, so an early, late or missing result is flagged. Register writes take effect at the next edge. Read data is therefore sampled in the following low clock phase, one time unit after the select settles, and lookups are issued only after the commit edge.

// File: rtl/pgwin_pkg.sv
package pgwin_pkg;
  localparam int ENT_W  = 16;
  localparam int FRM_W  = 12;
  localparam int EN_BIT = 15;
  localparam int RO_BIT = 14;
  // high data byte mask: reserved entry bits 13:12 sit at byte bits 5:4
  localparam logic [7:0] HI_KEEP = 8'hCF;

  typedef enum logic [1:0] {
    RSEL_INDEX = 2'd0,
    RSEL_LO    = 2'd1,
    RSEL_HI    = 2'd2,
    RSEL_NONE  = 2'd3
  } rsel_e;

  typedef struct packed {
    logic             en;
    logic             ro;
    logic [1:0]       rsv;
    logic [FRM_W-1:0] frame;
  } pte_t;
endpackage

// File: rtl/pgwin_rst_sync.sv
module pgwin_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sn = sync_q;
endmodule

// File: rtl/pgwin_table.sv
module pgwin_table #(
  parameter int IDX_W = 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [pgwin_pkg::ENT_W-1:0] wr_data,
  input  logic [IDX_W-1:0]          lk_idx,
  output logic [pgwin_pkg::ENT_W-1:0] lk_data,
  input  logic [IDX_W-1:0]          rl_idx,
  output logic [pgwin_pkg::ENT_W-1:0] rl_data
);
  import pgwin_pkg::*;

  logic [ENT_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0] row_we;

  // one-hot write decode, one enable per entry
  for (genvar i = 0; i < DEPTH; i++) begin : g_dec
    assign row_we[i] = wr_en && (wr_idx == IDX_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (row_we[i]) mem_q[i] <= wr_data;
      end
    end
  end

  assign lk_data = mem_q[lk_idx];
  assign rl_data = mem_q[rl_idx];
endmodule

// File: rtl/pgwin_regs.sv
module pgwin_regs #(
  parameter int IDX_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rg_we,
  input  logic [1:0]                  rg_sel,
  input  logic [7:0]                  rg_wdata,
  output logic [7:0]                  rg_rdata,
  output logic [IDX_W-1:0]            rl_idx,
  input  logic [pgwin_pkg::ENT_W-1:0] rl_data,
  output logic                        cm_en,
  output logic [IDX_W-1:0]            cm_idx,
  output logic [pgwin_pkg::ENT_W-1:0] cm_data
);
  import pgwin_pkg::*;

  logic [IDX_W-1:0] index_q, index_d;
  logic [7:0]       hold_q,  hold_d;
  logic [ENT_W-1:0] shadow_q, shadow_d;
  rsel_e            sel;

  assign sel     = rsel_e'(rg_sel);
  assign cm_en   = rg_we && (sel == RSEL_HI);
  assign cm_idx  = index_q;
  assign cm_data = {rg_wdata & HI_KEEP, hold_q};
  // table read port follows a new index in the cycle it is written
  assign rl_idx  = (rg_we && sel == RSEL_INDEX) ? rg_wdata[IDX_W-1:0] : index_q;

  always_comb begin
    index_d  = index_q;
    hold_d   = hold_q;
    shadow_d = shadow_q;
    if (rg_we) begin
      unique case (sel)
        RSEL_INDEX: begin
          index_d  = rg_wdata[IDX_W-1:0];
          shadow_d = rl_data;
        end
        RSEL_LO:    hold_d   = rg_wdata;
        RSEL_HI:    shadow_d = cm_data;
        RSEL_NONE:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q  <= '0;
      hold_q   <= '0;
      shadow_q <= '0;
    end else begin
      index_q  <= index_d;
      hold_q   <= hold_d;
      shadow_q <= shadow_d;
    end
  end

  always_comb begin
    unique case (sel)
      RSEL_INDEX: rg_rdata = 8'(index_q);
      RSEL_LO:    rg_rdata = shadow_q[7:0];
      RSEL_HI:    rg_rdata = shadow_q[15:8];
      RSEL_NONE:  rg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/pgwin_lookup.sv
module pgwin_lookup #(
  parameter int HOST_AW = 20,
  parameter int OFF_W   = 12,
  localparam int PHYS_AW = pgwin_pkg::FRM_W + OFF_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        lk_valid,
  input  logic                        lk_wr,
  input  logic [HOST_AW-1:0]          lk_addr,
  input  logic                        pte_en,
  input  logic                        pte_ro,
  input  logic [pgwin_pkg::FRM_W-1:0] pte_frame,
  output logic                        xl_valid,
  output logic [PHYS_AW-1:0]          xl_addr,
  output logic                        xl_hit,
  output logic                        xl_pass,
  output logic                        xl_wprot,
  output logic                        xl_mem_we
);
  logic               v_d, hit_d, pass_d, wp_d, we_d;
  logic [PHYS_AW-1:0] addr_d;
  logic               blocked;

  assign blocked = pte_en && pte_ro;

  always_comb begin
    v_d    = lk_valid;
    hit_d  = 1'b0;
    pass_d = 1'b0;
    wp_d   = 1'b0;
    we_d   = 1'b0;
    addr_d = '0;
    if (lk_valid) begin
      hit_d  = pte_en;
      pass_d = !pte_en;
      addr_d = pte_en ? {pte_frame, lk_addr[OFF_W-1:0]} : PHYS_AW'(lk_addr);
      wp_d   = lk_wr && blocked;
      we_d   = lk_wr && !blocked;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xl_valid  <= 1'b0;
      xl_addr   <= '0;
      xl_hit    <= 1'b0;
      xl_pass   <= 1'b0;
      xl_wprot  <= 1'b0;
      xl_mem_we <= 1'b0;
    end else begin
      xl_valid  <= v_d;
      xl_addr   <= addr_d;
      xl_hit    <= hit_d;
      xl_pass   <= pass_d;
      xl_wprot  <= wp_d;
      xl_mem_we <= we_d;
    end
  end
endmodule

// File: rtl/pgwin_xlat.sv
module pgwin_xlat #(
  parameter int HOST_AW = 20,
  parameter int OFF_W   = 12,
  localparam int IDX_W   = HOST_AW - OFF_W,
  localparam int PHYS_AW = pgwin_pkg::FRM_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic               lk_wr,
  input  logic [HOST_AW-1:0] lk_addr,
  output logic               xl_valid,
  output logic [PHYS_AW-1:0] xl_addr,
  output logic               xl_hit,
  output logic               xl_pass,
  output logic               xl_wprot,
  output logic               xl_mem_we,
  input  logic               rg_we,
  input  logic [1:0]         rg_sel,
  input  logic [7:0]         rg_wdata,
  output logic [7:0]         rg_rdata
);
  import pgwin_pkg::*;

  logic             rst_sn;
  logic [IDX_W-1:0] rl_idx, cm_idx;
  logic [ENT_W-1:0] rl_data, cm_data, lk_data;
  logic             cm_en;
  pte_t             pte;

  pgwin_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  pgwin_regs #(.IDX_W(IDX_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sn),
    .rg_we    (rg_we),
    .rg_sel   (rg_sel),
    .rg_wdata (rg_wdata),
    .rg_rdata (rg_rdata),
    .rl_idx   (rl_idx),
    .rl_data  (rl_data),
    .cm_en    (cm_en),
    .cm_idx   (cm_idx),
    .cm_data  (cm_data)
  );

  pgwin_table #(.IDX_W(IDX_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_sn),
    .wr_en   (cm_en),
    .wr_idx  (cm_idx),
    .wr_data (cm_data),
    .lk_idx  (lk_addr[HOST_AW-1:OFF_W]),
    .lk_data (lk_data),
    .rl_idx  (rl_idx),
    .rl_data (rl_data)
  );

  assign pte = pte_t'(lk_data);

  pgwin_lookup #(.HOST_AW(HOST_AW), .OFF_W(OFF_W)) u_lookup (
    .clk       (clk),
    .rst_n     (rst_sn),
    .lk_valid  (lk_valid),
    .lk_wr     (lk_wr),
    .lk_addr   (lk_addr),
    .pte_en    (pte.en),
    .pte_ro    (pte.ro),
    .pte_frame (pte.frame),
    .xl_valid  (xl_valid),
    .xl_addr   (xl_addr),
    .xl_hit    (xl_hit),
    .xl_pass   (xl_pass),
    .xl_wprot  (xl_wprot),
    .xl_mem_we (xl_mem_we)
  );
endmodule

// File: rtl/pgwin_xlat_chk.sv
module pgwin_xlat_chk #(
  parameter int HOST_AW = 20,
  parameter int PHYS_AW = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_wr,
  input logic [HOST_AW-1:0] lk_addr,
  input logic               xl_valid,
  input logic [PHYS_AW-1:0] xl_addr,
  input logic               xl_hit,
  input logic               xl_pass,
  input logic               xl_wprot,
  input logic               xl_mem_we,
  input logic [1:0]         rg_sel,
  input logic [7:0]         rg_rdata
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> xl_valid); // R4
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !xl_valid); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_valid |-> !(xl_hit || xl_pass || xl_wprot || xl_mem_we) && xl_addr == '0); // R4
  AST_HIT_XOR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid |-> $onehot({xl_hit, xl_pass})); // R2
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> xl_addr[11:0] == $past(lk_addr[11:0])); // R2
  AST_PASS_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid ##1 xl_pass) |-> xl_addr == PHYS_AW'($past(lk_addr))); // R3
  AST_WPROT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    xl_wprot |-> !xl_mem_we && xl_hit); // R8
  AST_WPROT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !lk_wr |=> !xl_wprot && !xl_mem_we); // R8
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rg_sel == 2'd2 |-> rg_rdata[5:4] == 2'b00); // R6
  AST_SEL3_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rg_sel == 2'd3 |-> rg_rdata == 8'h00); // R7
endmodule

bind pgwin_xlat pgwin_xlat_chk #(.HOST_AW(HOST_AW), .PHYS_AW(PHYS_AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sn),
  .lk_valid  (lk_valid),
  .lk_wr     (lk_wr),
  .lk_addr   (lk_addr),
  .xl_valid  (xl_valid),
  .xl_addr   (xl_addr),
  .xl_hit    (xl_hit),
  .xl_pass   (xl_pass),
  .xl_wprot  (xl_wprot),
  .xl_mem_we (xl_mem_we),
  .rg_sel    (rg_sel),
  .rg_rdata  (rg_rdata)
);

// File: tb/pgwin_xlat_bench.sv
`timescale 1ns/1ps
module pgwin_xlat_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_wr = 1'b0;
  logic [19:0] lk_addr = '0;
  logic        xl_valid, xl_hit, xl_pass, xl_wprot, xl_mem_we;
  logic [23:0] xl_addr;
  logic        rg_we = 1'b0;
  logic [1:0]  rg_sel = 2'd0;
  logic [7:0]  rg_wdata = '0;
  logic [7:0]  rg_rdata;

  always #4 clk = ~clk;

  pgwin_xlat u_pgwin_xlat (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_wr(lk_wr), .lk_addr(lk_addr),
    .xl_valid(xl_valid), .xl_addr(xl_addr), .xl_hit(xl_hit), .xl_pass(xl_pass),
    .xl_wprot(xl_wprot), .xl_mem_we(xl_mem_we), .rg_we(rg_we), .rg_sel(rg_sel),
    .rg_wdata(rg_wdata), .rg_rdata(rg_rdata)
  );

  typedef struct {
    int          due;
    logic [23:0] addr;
    logic        hit, pass, wp, we;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [15:0] model [256];
  logic [7:0]  m_idx;
  logic [7:0]  m_hold;
  int          cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          live = 0;
  bit          done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard monitor
  always @(posedge clk) begin
    #2;
    if (live) begin
      if (sb.size() > 0 && sb[0].due == cyc) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (!xl_valid || xl_addr !== e.addr || xl_hit !== e.hit || xl_pass !== e.pass ||
            xl_wprot !== e.wp || xl_mem_we !== e.we) begin
          n_fail++;
          $display("FAIL %s: got v=%b a=%h h=%b p=%b wp=%b we=%b exp v=1 a=%h h=%b p=%b wp=%b we=%b",
                   e.tag, xl_valid, xl_addr, xl_hit, xl_pass, xl_wprot, xl_mem_we,
                   e.addr, e.hit, e.pass, e.wp, e.we);
        end
      end else if (xl_valid) begin
        n_chk++;
        n_fail++;
        $display("FAIL R4: got unexpected xl_valid=1 at cycle %0d exp 0", cyc);
      end
    end
  end

  task automatic lookup(input logic [19:0] a, input logic w, input string tag);
    exp_t        e;
    logic [15:0] ent;
    @(negedge clk);
    lk_valid = 1'b1;
    lk_addr  = a;
    lk_wr    = w;
    ent      = model[a[19:12]];
    e.due    = cyc + 1;
    e.hit    = ent[15];
    e.pass   = !ent[15];
    e.addr   = ent[15] ? {ent[11:0], a[11:0]} : {4'h0, a};
    e.wp     = w && ent[15] && ent[14];
    e.we     = w && !(ent[15] && ent[14]);
    e.tag    = tag;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    lk_valid = 1'b0;
    lk_wr    = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    rg_we = 1'b1; rg_sel = s; rg_wdata = d;
    case (s)
      2'd0: m_idx = d;
      2'd1: m_hold = d;
      2'd2: model[m_idx] = {d & 8'hCF, m_hold};
      default: ;
    endcase
    @(negedge clk);
    rg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] s, input string tag);
    logic [7:0] exp;
    @(negedge clk);
    rg_sel = s;
    #1;
    case (s)
      2'd0: exp = m_idx;
      2'd1: exp = model[m_idx][7:0];
      2'd2: exp = model[m_idx][15:8];
      default: exp = 8'h00;
    endcase
    n_chk++;
    if (rg_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s: rg_rdata sel=%0d got %h exp %h", tag, s, rg_rdata, exp);
    end
  endtask

  task automatic check_quiet(input string tag);
    n_chk++;
    if (xl_valid || xl_hit || xl_pass || xl_wprot || xl_mem_we || xl_addr !== 24'h0) begin
      n_fail++;
      $display("FAIL %s: outputs got v=%b h=%b p=%b wp=%b we=%b a=%h exp all zero",
               tag, xl_valid, xl_hit, xl_pass, xl_wprot, xl_mem_we, xl_addr);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 16'h0000;
    m_idx = '0; m_hold = '0;
    repeat (3) @(negedge clk);
    check_quiet("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    live = 1;
    check_quiet("R1 after reset");
    // R1: empty table, index 0
    reg_read(2'd0, "R1 index");
    reg_read(2'd1, "R1 entry lo");
    reg_read(2'd2, "R1 entry hi");
    reg_write(2'd0, 8'hA7);
    reg_read(2'd2, "R1 entry A7 hi");
    // R3: disabled pages pass through, both ends of the window
    lookup(20'h00000, 1'b0, "R3 pass low");
    lookup(20'hFFFFF, 1'b1, "R3 R9 pass write");
    idle();
    // R6: program page 0x12, reserved bits set in the write
    reg_write(2'd0, 8'h12);
    reg_write(2'd1, 8'h34);
    reg_write(2'd2, 8'hB5);
    reg_read(2'd2, "R6 reserved cleared");
    reg_read(2'd1, "R6 low committed");
    // R2 R9: enabled read-write page
    lookup(20'h12ABC, 1'b0, "R2 hit read");
    lookup(20'h12001, 1'b1, "R9 hit write rw");
    lookup(20'h13001, 1'b0, "R3 neighbour disabled");
    idle();
    // R7: index reload of read data
    reg_write(2'd0, 8'h13);
    reg_read(2'd1, "R7 reload 13 lo");
    reg_write(2'd0, 8'h12);
    reg_read(2'd0, "R7 index readback");
    reg_read(2'd2, "R7 reload 12 hi");
    // R5: low byte alone changes nothing
    reg_write(2'd1, 8'h99);
    reg_read(2'd1, "R5 low not committed");
    lookup(20'h12000, 1'b0, "R5 lookup old entry");
    idle();
    // R8: commit read-only enabled page
    reg_write(2'd2, 8'hC0);
    reg_read(2'd2, "R8 ro entry hi");
    lookup(20'h12FFF, 1'b1, "R8 ro write blocked");
    lookup(20'h12FFF, 1'b0, "R8 ro read");
    idle();
    // R9 R3: read-only flag ignored on disabled page
    reg_write(2'd0, 8'h40);
    reg_write(2'd1, 8'h11);
    reg_write(2'd2, 8'h40);
    lookup(20'h40123, 1'b1, "R9 disabled ro write");
    idle();
    // R2: top page to top frame
    reg_write(2'd0, 8'hFF);
    reg_write(2'd1, 8'hFF);
    reg_write(2'd2, 8'h8F);
    lookup(20'hFFFFF, 1'b1, "R2 top page");
    idle();
    // R7: select 3 write has no effect, reads zero
    reg_write(2'd3, 8'h77);
    reg_read(2'd3, "R7 sel3 reads zero");
    reg_read(2'd0, "R7 sel3 index kept");
    reg_read(2'd1, "R7 sel3 entry kept");
    lookup(20'hFF800, 1'b0, "R7 sel3 table kept");
    idle();
    // R4: back-to-back lookups across several pages
    for (int k = 0; k < 8; k++) begin
      lookup({8'h10 + 8'(k), 12'(k * 300)}, k[0], "R4 back-to-back");
    end
    lookup(20'h12345, 1'b1, "R4 back-to-back ro");
    lookup(20'hFF010, 1'b0, "R4 back-to-back top");
    idle();
    repeat (4) @(negedge clk);
    n_chk++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R4: pending results got %0d exp 0", sb.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R4: watchdog expired got hang exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule